// File: doc/BRIEF.md
# Interrupt Cycle Sequencer

This block is the control state machine of a small processor model. It walks every instruction through a fetch cycle and a one-cycle execute cycle. A device can raise an interrupt request at any time, but the request is only looked at once the current instruction has finished executing. If a request is pending and interrupts are enabled, the sequencer inserts a separate interrupt cycle. In that cycle it saves the return address and the status word on a small internal control stack. It then disables interrupts, loads the handler entry address into the program counter, and acknowledges the device with a one-cycle pulse.

A return command, given while an instruction executes, pops the newest saved frame. This restores the program counter and the whole status word, including the interrupt-enable bit, so the interrupted program resumes where it left off. Nesting happens only when a handler executes an instruction that re-enables interrupts. The stack holds four frames. A push beyond that is dropped and raises a sticky overflow flag.

Top module: `intr_cycle_seq`

## Requirements
- R1: After a synchronous reset, phase is fetch (code 0), pc is 0, the status word is 0 (interrupts disabled), the stack is empty, int_ack is 0 and stk_ovf is 0.
- R2: A fetch cycle (code 0) increments pc by 1 and is followed by one execute cycle (code 1, instr_done high). The interrupt phase (code 2) occurs only directly after an execute cycle, lasts one cycle and is followed by fetch.
- R3: At the end of an execute cycle the sequencer enters the interrupt phase only if a request is pending and the enable bit (psw bit 0) was set at the start of that cycle; otherwise it goes to fetch. A request counts as pending if irq_req is high in that cycle or was seen high in an earlier cycle and not yet accepted, so a one-cycle pulse is remembered.
- R4: int_ack is high for exactly the one cycle after the interrupt phase. irq_req held high while int_ack is high is not counted as a new request.
- R5: The interrupt phase pushes a frame holding pc (the address of the next instruction) and the status word, clears the enable bit, and loads pc with handler_addr as sampled in that cycle.
- R6: A non-return instruction loads psw bits 7..1 from op_flags during execute. op_set_ie sets psw bit 0; it never clears it. pc is unchanged by execute.
- R7: op_ret in an execute cycle with a non-empty stack pops the newest frame and restores pc and the full status word, including the enable bit.
- R8: op_ret with an empty stack is treated as an ordinary instruction: pc keeps its fetched value and psw is updated as in R6.
- R9: The stack is last-in first-out and four frames deep. A push with four frames held is dropped, stk_depth stays 4 and stk_ovf is set and stays set until reset; the vector to the handler still happens.
- R10: A handler that re-enables interrupts accepts further requests, each pushing its own frame, and returns unwind them in reverse order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 1 | Interrupt request from the device |
| handler_addr | input | 16 | Handler entry address, sampled in the interrupt phase |
| op_ret | input | 1 | Current instruction is a return from handler (sampled in execute) |
| op_set_ie | input | 1 | Current instruction enables interrupts (sampled in execute) |
| op_flags | input | 7 | Condition flags produced by the current instruction (sampled in execute) |
| phase | output | 2 | Current phase: 0 fetch, 1 execute, 2 interrupt |
| instr_done | output | 1 | High in the execute cycle, where the instruction completes |
| pc | output | 16 | Program counter |
| psw | output | 8 | Status word: bits 7..1 flags, bit 0 interrupt enable |
| int_ack | output | 1 | One-cycle acknowledge to the device |
| stk_depth | output | 3 | Number of frames on the control stack |
| stk_ovf | output | 1 | Sticky flag: a push found the stack full |

## Verification
The hardest state to reach is the full control stack with overflow. Getting there takes five accepted interrupts in a row, and each one needs the handler to execute an enabling instruction first, because entry always clears the enable bit. The bench repeats a three-step pattern: raise the request, run an instruction that takes it, then run a handler instruction that re-enables interrupts while the acknowledge is dropped. It repeats this six times and then unwinds the stack with returns, checking every restored address and status word. The masking of a request that is still held during the acknowledge cycle is shown by running two further instructions with interrupts enabled and observing that neither enters the interrupt phase.

// File: rtl/intr_seq_pkg.sv
package intr_seq_pkg;

    localparam int PC_W   = 16;
    localparam int FLAG_W = 7;

    typedef enum logic [1:0] {
        PH_FETCH = 2'd0,
        PH_EXEC  = 2'd1,
        PH_INTR  = 2'd2
    } phase_e;

    typedef struct packed {
        logic [FLAG_W-1:0] flags;
        logic              ie;
    } psw_t;

    localparam int PSW_W = $bits(psw_t);

    typedef struct packed {
        psw_t            psw;
        logic [PC_W-1:0] pc;
    } frame_t;

    // Status word after an ordinary instruction completes.
    function automatic psw_t psw_after_exec(psw_t cur, logic [FLAG_W-1:0] flg, logic set_ie);
        psw_t r;
        r.flags = flg;
        r.ie    = cur.ie | set_ie;
        return r;
    endfunction

    // Status word on entry to a handler: enable bit dropped.
    function automatic psw_t psw_on_entry(psw_t cur);
        psw_t r;
        r    = cur;
        r.ie = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/req_tracker.sv
module req_tracker (
    input  logic clk,
    input  logic rst,
    input  logic irq_req,
    input  logic ack_active,
    input  logic accept,
    output logic pending
);
    logic pend_q;
    logic req_seen;

    // A request held during the acknowledge cycle is the old one.
    assign req_seen = irq_req & ~ack_active;
    assign pending  = pend_q | req_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
        end else if (accept) begin
            pend_q <= 1'b0;
        end else if (req_seen) begin
            pend_q <= 1'b1;
        end
    end

    // R3: accepting a request empties the latch
    a_r3_pend_cleared: assert property (@(posedge clk) disable iff (rst)
        accept |=> !pend_q);

    // R4: a request seen only during acknowledge is never latched
    a_r4_ack_masks_req: assert property (@(posedge clk) disable iff (rst)
        (ack_active && !pend_q && !accept) |=> !pend_q);

endmodule

// File: rtl/ctl_stack.sv
module ctl_stack
    import intr_seq_pkg::*;
#(
    parameter int STK_DEPTH = 4,
    localparam int CNT_W = $clog2(STK_DEPTH + 1),
    localparam int IDX_W = (STK_DEPTH > 1) ? $clog2(STK_DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    input  frame_t           din,
    output frame_t           dout,
    output logic [CNT_W-1:0] depth,
    output logic             ovf
);
    logic [CNT_W-1:0] sp_q;
    logic             full;
    logic             empty;
    logic             wr_en;
    logic [IDX_W-1:0] rd_idx;
    frame_t           slots [STK_DEPTH];

    assign full   = (sp_q == CNT_W'(STK_DEPTH));
    assign empty  = (sp_q == '0);
    assign wr_en  = push & ~full;
    assign rd_idx = IDX_W'(sp_q - CNT_W'(1));

    for (genvar i = 0; i < STK_DEPTH; i++) begin : g_slot
        frame_t slot_q;
        always_ff @(posedge clk) begin
            if (wr_en && sp_q == CNT_W'(i)) begin
                slot_q <= din;
            end
        end
        assign slots[i] = slot_q;
    end

    assign dout  = slots[rd_idx];
    assign depth = sp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_q <= '0;
            ovf  <= 1'b0;
        end else begin
            if (wr_en) begin
                sp_q <= sp_q + CNT_W'(1);
            end else if (pop && !empty) begin
                sp_q <= sp_q - CNT_W'(1);
            end
            if (push && full) begin
                ovf <= 1'b1;
            end
        end
    end

    // R9: depth never exceeds the configured number of frames
    a_r9_depth_bound: assert property (@(posedge clk) disable iff (rst)
        depth <= CNT_W'(STK_DEPTH));

    // R9: overflow flag is sticky
    a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf);

    // R9: a push into a full stack leaves the depth unchanged
    a_r9_full_drop: assert property (@(posedge clk) disable iff (rst)
        (push && full) |=> (depth == CNT_W'(STK_DEPTH)) && ovf);

    // R7: push and pop are never requested together
    a_r7_no_push_pop: assert property (@(posedge clk) disable iff (rst)
        !(push && pop));

endmodule

// File: rtl/cycle_fsm.sv
module cycle_fsm
    import intr_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   pending,
    input  logic   ie,
    output phase_e phase
);
    phase_e phase_q;
    phase_e phase_d;

    always_comb begin
        unique case (phase_q)
            PH_FETCH: phase_d = PH_EXEC;
            PH_EXEC:  phase_d = (pending && ie) ? PH_INTR : PH_FETCH;
            PH_INTR:  phase_d = PH_FETCH;
            default:  phase_d = PH_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_FETCH;
        end else begin
            phase_q <= phase_d;
        end
    end

    assign phase = phase_q;

    // R2: the interrupt phase only follows an execute cycle
    a_r2_intr_after_exec: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_INTR) |-> ($past(phase_q) == PH_EXEC));

    // R2: fetch is always followed by execute
    a_r2_fetch_then_exec: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_FETCH) |=> (phase_q == PH_EXEC));

    // R3: no interrupt phase while interrupts are disabled
    a_r3_gated_by_ie: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_EXEC && !ie) |=> (phase_q == PH_FETCH));

endmodule

// File: rtl/intr_cycle_seq.sv
module intr_cycle_seq
    import intr_seq_pkg::*;
#(
    parameter int STK_DEPTH = 4,
    localparam int CNT_W = $clog2(STK_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              irq_req,
    input  logic [PC_W-1:0]   handler_addr,
    input  logic              op_ret,
    input  logic              op_set_ie,
    input  logic [FLAG_W-1:0] op_flags,
    output logic [1:0]        phase,
    output logic              instr_done,
    output logic [PC_W-1:0]   pc,
    output logic [PSW_W-1:0]  psw,
    output logic              int_ack,
    output logic [CNT_W-1:0]  stk_depth,
    output logic              stk_ovf
);
    phase_e          ph;
    logic            in_exec;
    logic            in_intr;
    logic            pending;
    logic            stk_empty;
    logic            do_pop;
    logic [PC_W-1:0] pc_q;
    psw_t            psw_q;
    logic            ack_q;
    frame_t          push_frame;
    frame_t          top_frame;
    logic [CNT_W-1:0] depth_w;

    assign in_exec   = (ph == PH_EXEC);
    assign in_intr   = (ph == PH_INTR);
    assign stk_empty = (depth_w == '0);
    assign do_pop    = in_exec & op_ret & ~stk_empty;

    assign push_frame.pc  = pc_q;
    assign push_frame.psw = psw_q;

    req_tracker u_req (
        .clk        (clk),
        .rst        (rst),
        .irq_req    (irq_req),
        .ack_active (ack_q),
        .accept     (in_intr),
        .pending    (pending)
    );

    cycle_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .pending (pending),
        .ie      (psw_q.ie),
        .phase   (ph)
    );

    ctl_stack #(.STK_DEPTH(STK_DEPTH)) u_stk (
        .clk   (clk),
        .rst   (rst),
        .push  (in_intr),
        .pop   (do_pop),
        .din   (push_frame),
        .dout  (top_frame),
        .depth (depth_w),
        .ovf   (stk_ovf)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= '0;
            psw_q <= '0;
            ack_q <= 1'b0;
        end else begin
            ack_q <= in_intr;
            unique case (ph)
                PH_FETCH: pc_q <= pc_q + PC_W'(1);
                PH_EXEC: begin
                    if (do_pop) begin
                        pc_q  <= top_frame.pc;
                        psw_q <= top_frame.psw;
                    end else begin
                        psw_q <= psw_after_exec(psw_q, op_flags, op_set_ie);
                    end
                end
                PH_INTR: begin
                    pc_q  <= handler_addr;
                    psw_q <= psw_on_entry(psw_q);
                end
                default: ;
            endcase
        end
    end

    assign phase      = ph;
    assign instr_done = in_exec;
    assign pc         = pc_q;
    assign psw        = psw_q;
    assign int_ack    = ack_q;
    assign stk_depth  = depth_w;

    // R4: acknowledge is a single-cycle pulse
    a_r4_ack_pulse: assert property (@(posedge clk) disable iff (rst)
        int_ack |=> !int_ack);

    // R4: acknowledge follows the interrupt phase
    a_r4_ack_after_intr: assert property (@(posedge clk) disable iff (rst)
        in_intr |=> int_ack);

    // R5: handler entry vectors pc and disables interrupts
    a_r5_vector: assert property (@(posedge clk) disable iff (rst)
        in_intr |=> (pc == $past(handler_addr)) && !psw_q.ie);

    // R6: execute never moves pc unless a frame is popped
    a_r6_exec_keeps_pc: assert property (@(posedge clk) disable iff (rst)
        (in_exec && !do_pop) |=> $stable(pc));

endmodule

// File: tb/intr_cycle_seq_tb_top.sv
module intr_cycle_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 20000;

    logic        clk = 1'b0;
    logic        rst;
    logic        irq_req;
    logic [15:0] handler_addr;
    logic        op_ret;
    logic        op_set_ie;
    logic [6:0]  op_flags;
    logic [1:0]  phase;
    logic        instr_done;
    logic [15:0] pc;
    logic [7:0]  psw;
    logic        int_ack;
    logic [2:0]  stk_depth;
    logic        stk_ovf;

    int   n_checks = 0;
    int   n_errors = 0;
    bit   finished = 1'b0;

    // bench-side expectations
    logic [15:0] e_pc;
    logic [7:0]  e_psw;
    int          e_depth;
    bit          e_ovf;
    logic [15:0] s_pc  [4];
    logic [7:0]  s_psw [4];

    always #(CLK_PERIOD / 2) clk = ~clk;

    intr_cycle_seq dut_i (
        .clk          (clk),
        .rst          (rst),
        .irq_req      (irq_req),
        .handler_addr (handler_addr),
        .op_ret       (op_ret),
        .op_set_ie    (op_set_ie),
        .op_flags     (op_flags),
        .phase        (phase),
        .instr_done   (instr_done),
        .pc           (pc),
        .psw          (psw),
        .int_ack      (int_ack),
        .stk_depth    (stk_depth),
        .stk_ovf      (stk_ovf)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk_state(input string req);
        chk(pc == e_pc, {req, " pc"}, 32'(pc), 32'(e_pc));
        chk(psw == e_psw, {req, " psw"}, 32'(psw), 32'(e_psw));
        chk(int'(stk_depth) == e_depth, {req, " depth"}, 32'(stk_depth), 32'(e_depth));
        chk(stk_ovf == e_ovf, {req, " ovf"}, 32'(stk_ovf), 32'(e_ovf));
    endtask

    task automatic do_reset();
        rst = 1'b1; irq_req = 1'b0; handler_addr = 16'h0;
        op_ret = 1'b0; op_set_ie = 1'b0; op_flags = 7'h0;
        tick(); tick();
        rst = 1'b0;
        e_pc = 16'h0; e_psw = 8'h0; e_depth = 0; e_ovf = 1'b0;
        // R1: reset state
        chk(phase == 2'd0, "R1 phase", 32'(phase), 0);
        chk(int_ack == 1'b0, "R1 ack", 32'(int_ack), 0);
        chk_state("R1");
    endtask

    // one instruction: fetch cycle then execute cycle
    task automatic do_instr(input bit ret, input bit sie, input logic [6:0] flg,
                            input bit exp_intr, input bit pulse, input string req);
        bit ackd;
        chk(phase == 2'd0, {req, " R2 start in fetch"}, 32'(phase), 0);
        ackd = int_ack;
        tick();
        if (ackd || pulse) irq_req = 1'b0;
        e_pc = e_pc + 16'd1;
        // R2: fetch increments pc and leads to execute
        chk(phase == 2'd1, {req, " R2 exec phase"}, 32'(phase), 1);
        chk(instr_done == 1'b1, {req, " R2 instr_done"}, 32'(instr_done), 1);
        chk(pc == e_pc, {req, " R2 pc after fetch"}, 32'(pc), 32'(e_pc));
        op_ret = ret; op_set_ie = sie; op_flags = flg;
        tick();
        op_ret = 1'b0; op_set_ie = 1'b0; op_flags = 7'h0;
        if (ret && e_depth > 0) begin
            e_depth--;
            e_pc  = s_pc[e_depth];
            e_psw = s_psw[e_depth];
        end else begin
            e_psw = {flg, e_psw[0] | sie};
        end
        // R3: interrupt phase only when pending and enabled
        chk(phase == (exp_intr ? 2'd2 : 2'd0), {req, " R3 next phase"},
            32'(phase), exp_intr ? 2 : 0);
        chk(int_ack == 1'b0, {req, " R4 no ack"}, 32'(int_ack), 0);
        chk_state(req);
    endtask

    // the interrupt cycle itself
    task automatic take_intr(input logic [15:0] h, input string req);
        handler_addr = h;
        tick();
        handler_addr = 16'hDEAD;
        if (e_depth < 4) begin
            s_pc[e_depth]  = e_pc;
            s_psw[e_depth] = e_psw;
            e_depth++;
        end else begin
            e_ovf = 1'b1;
        end
        e_pc = h;
        e_psw[0] = 1'b0;
        // R5: vector, IE cleared, frame pushed; R4: ack pulse
        chk(phase == 2'd0, {req, " R2 fetch after intr"}, 32'(phase), 0);
        chk(int_ack == 1'b1, {req, " R4 ack"}, 32'(int_ack), 1);
        chk_state({req, " R5"});
    endtask

    initial begin
        do_reset();

        // R3: request ignored while interrupts are disabled
        irq_req = 1'b1;
        do_instr(0, 0, 7'h11, 0, 0, "R3 ie off");
        // R6: set enable; old enable was 0 so still no interrupt
        do_instr(0, 1, 7'h22, 0, 0, "R6 set ie");
        do_instr(0, 0, 7'h33, 1, 0, "R3 taken");
        take_intr(16'h0400, "R5 first");
        // R4: request still high during ack; dropped afterwards
        do_instr(0, 0, 7'h05, 0, 0, "R4 handler");
        do_instr(0, 1, 7'h06, 0, 0, "R4 reenable");
        do_instr(0, 0, 7'h07, 0, 0, "R4 no second request");
        // R7: return restores pc and psw
        do_instr(1, 0, 7'h00, 0, 0, "R7 return");
        chk(psw[0] == 1'b1, "R7 ie restored", 32'(psw), 32'(e_psw));

        // R3: a one-cycle pulse is remembered
        irq_req = 1'b1;
        do_instr(0, 0, 7'h44, 1, 1, "R3 pulse");
        take_intr(16'h0800, "R5 pulse");
        do_instr(1, 0, 7'h00, 0, 0, "R7 return pulse");

        // R10 / R9: nested sweep past the stack depth
        for (int k = 1; k <= 6; k++) begin
            irq_req = 1'b1;
            do_instr(0, 0, 7'(k), 1, 0, "R10 nest request");
            take_intr(16'h1000 + 16'(k) * 16'h0100, k > 4 ? "R9 overflow push" : "R10 nest push");
            do_instr(0, 1, 7'(k + 8), 0, 0, "R10 handler enable");
        end
        chk(stk_ovf == 1'b1, "R9 ovf set", 32'(stk_ovf), 1);
        chk(stk_depth == 3'd4, "R9 depth full", 32'(stk_depth), 4);

        for (int k = 0; k < 4; k++) begin
            do_instr(1, 0, 7'h00, 0, 0, "R10 unwind");
        end
        // R8: return with empty stack is an ordinary instruction
        do_instr(1, 0, 7'h55, 0, 0, "R8 empty return");
        chk(stk_ovf == 1'b1, "R9 ovf sticky", 32'(stk_ovf), 1);

        // R1: reset clears the overflow flag
        do_reset();

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (MAX_CYCLES) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule